// File: doc/BRIEF.md
# Parallel Logarithmic-Search Motion Estimator

This block finds the motion vector of one 16x16 macroblock of 8-bit pixels against a reference search window, using a two-dimensional logarithmic search. The block works in steps. In each step it scores five candidate positions in parallel: the current centre and the four points of a cross around it, all at the current step distance. Five sum-of-absolute-difference engines do the scoring, one engine for each candidate. At the end of a step the centre moves to the candidate with the lowest score and the step distance halves. After the last step the block reports the final displacement and its score.

The current macroblock sits in a 256-entry local buffer that is written through a simple write port while the block is idle. The reference window is 78x78 pixels with displacement (0,0) at window coordinate (31,31). It is read through five synchronous read lanes, one per engine, with one cycle of read latency. A search is either three steps long (starting distance 4, reach ±7) or five steps long (starting distance 16, reach ±31). The length is chosen when the search starts.

Top module: `logsearch_me`

## Requirements
- R1: During and after reset, busy and done are 0, mv_x and mv_y are 0, and min_sad is 0.
- R2: A start pulse seen while idle makes busy high from the next cycle for N*258 cycles, where N is 5 if five_step was 1 at start and 3 otherwise. The done signal is then high for exactly one cycle with busy low, and busy and done are never high together.
- R3: Each score is accumulated over all 256 pixel differences in 16 bits without wrapping, so the worst case 256*255 = 65280 is reported exactly.
- R4: The five lanes serve the candidates in a fixed order: lane 0 is the centre (x,y), lane 1 is up (x, y-s), lane 2 is left (x-s, y), lane 3 is right (x+s, y) and lane 4 is down (x, y+s). For pixel index p = row*16+col, issued in order p = 0..255, lane k reads address (31+Y+row)*78 + (31+X+col), where (X,Y) is that lane's candidate, and uses the data one cycle later. The lane addresses sit in ref_addr at bits [13k+12:13k], and the data in ref_data at bits [8k+7:8k].
- R5: The step distance starts at 2^(N-1) and halves after each step. The last step uses distance 1. A change of five_step while busy has no effect on the current search.
- R6: After each step the centre moves to the candidate with the strictly lowest score. When scores are equal, the centre is preferred first, then up, left, right and down, in that order.
- R7: A candidate outside ±(2^N−1) in either axis scores 65535 and so can never be chosen. The reported mv_x and mv_y always lie within ±(2^N−1).
- R8: When done is high, mv_x and mv_y (6-bit two's complement) hold the final centre and min_sad holds its score from the last step. These values stay unchanged until the next done.
- R9: A start pulse while busy is ignored: the search in progress and its timing are unchanged.
- R10: A write with cur_we high stores cur_wdata at cur_waddr, which is pixel index row*16+col, into the macroblock buffer used by the next search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_we | input | 1 | Macroblock buffer write enable |
| cur_waddr | input | 8 | Macroblock pixel index row*16+col |
| cur_wdata | input | 8 | Macroblock pixel value |
| start | input | 1 | Starts a search when idle |
| five_step | input | 1 | 1 selects a five-step search, 0 a three-step search; sampled at start |
| ref_addr | output | 65 | Five 13-bit reference window read addresses, lane k at bits [13k+12:13k] |
| ref_data | input | 40 | Five 8-bit reference pixels, one cycle after their addresses |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result pulse |
| mv_x | output | 6 | Signed horizontal displacement |
| mv_y | output | 6 | Signed vertical displacement (negative is up) |
| min_sad | output | 16 | Score of the reported displacement |

## Verification
If the start pulse is sampled at clock edge 0, the block is busy after edges 0 through N*258−1, and done is high after edge N*258. The bench compares busy and done against that schedule after every edge of the run. It reads the result at the done cycle and again one cycle later, to check that the result is held. The first lane addresses are due right after edge 0, because the centre and step are loaded at that edge, so the bench checks them at that point against the address formula. The expected vector and score come from a behavioural search in the bench over the same pixel functions that feed the reference lanes.

// File: rtl/me_pkg.sv
`timescale 1ns/1ps
package me_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_EVAL, ST_DONE} me_state_t;

  localparam int NLANE = 5;

  // |a-b| on 16-bit operands; engines zero-extend their pixels into it
  function automatic logic [15:0] abs_diff(input logic [15:0] a, input logic [15:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // unit direction of each lane: 0 centre, 1 up, 2 left, 3 right, 4 down
  function automatic int lane_dx(input int lane);
    case (lane)
      2:       return -1;
      3:       return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int lane_dy(input int lane);
    case (lane)
      1:       return -1;
      4:       return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int clamp_int(input int v, input int lim);
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic logic inside_box(input int ox, input int oy, input int lim);
    return (ox <= lim) && (ox >= -lim) && (oy <= lim) && (oy >= -lim);
  endfunction
endpackage

// File: rtl/me_curbuf.sv
`timescale 1ns/1ps
module me_curbuf #(
  parameter int PW    = 8,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [PW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [PW-1:0] rdata
);
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/me_pe.sv
`timescale 1ns/1ps
module me_pe #(
  parameter int PW = 8,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          force_max,
  input  logic [PW-1:0] cur_px,
  input  logic [PW-1:0] ref_px,
  output logic [SW-1:0] sad
);
  logic [SW-1:0] acc;
  logic [15:0]   diff;

  assign diff = me_pkg::abs_diff(16'(cur_px), 16'(ref_px));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= acc + SW'(diff);
  end

  assign sad = force_max ? '1 : acc;
endmodule

// File: rtl/me_ctrl.sv
`timescale 1ns/1ps
module me_ctrl
  import me_pkg::*;
#(
  parameter int SW       = 16,
  parameter int NPIX     = 256,
  parameter int STEPS_LO = 3,
  parameter int STEPS_HI = 5,
  parameter int CW       = 6,
  parameter int CNTW     = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 five_step,
  input  logic [NLANE*SW-1:0]  sad_all,
  output me_state_t            state,
  output logic [CNTW-1:0]      cnt,
  output logic                 issue,
  output logic                 rd_vld,
  output logic                 clr,
  output logic signed [CW-1:0] cx,
  output logic signed [CW-1:0] cy,
  output logic [CW-1:0]        step_dist,
  output logic [CW-1:0]        lim,
  output logic                 five_q,
  output logic                 eval_evt,
  output logic                 last_step,
  output logic [2:0]           best_idx,
  output logic                 busy,
  output logic                 done,
  output logic signed [CW-1:0] mv_x,
  output logic signed [CW-1:0] mv_y,
  output logic [SW-1:0]        min_sad
);
  localparam int RMAX = (1 << STEPS_HI) - 1;
  localparam int RLO  = (1 << STEPS_LO) - 1;

  logic [SW-1:0] best_sad;
  int            nx_i, ny_i;

  assign issue     = (state == ST_RUN) && (cnt < CNTW'(NPIX));
  assign eval_evt  = (state == ST_EVAL);
  assign last_step = (step_dist == CW'(1));
  assign busy      = (state == ST_RUN) || (state == ST_EVAL);
  assign done      = (state == ST_DONE);
  assign lim       = five_q ? CW'(RMAX) : CW'(RLO);
  assign clr       = ((state == ST_IDLE) && start) || (eval_evt && !last_step);

  // lowest score wins; strict compare keeps the lane order as tie priority
  always_comb begin
    best_idx = 3'd0;
    best_sad = sad_all[SW-1:0];
    for (int k = 1; k < NLANE; k++) begin
      if (sad_all[k*SW +: SW] < best_sad) begin
        best_idx = 3'(k);
        best_sad = sad_all[k*SW +: SW];
      end
    end
    nx_i = int'(cx) + lane_dx(int'(best_idx)) * int'(step_dist);
    ny_i = int'(cy) + lane_dy(int'(best_idx)) * int'(step_dist);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rd_vld    <= 1'b0;
      cx        <= '0;
      cy        <= '0;
      step_dist <= '0;
      five_q    <= 1'b0;
      mv_x      <= '0;
      mv_y      <= '0;
      min_sad   <= '0;
    end else begin
      rd_vld <= issue;
      case (state)
        ST_IDLE: if (start) begin
          state     <= ST_RUN;
          cnt       <= '0;
          cx        <= '0;
          cy        <= '0;
          five_q    <= five_step;
          step_dist <= five_step ? CW'(1 << (STEPS_HI - 1)) : CW'(1 << (STEPS_LO - 1));
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNTW'(NPIX)) state <= ST_EVAL;
        end
        ST_EVAL: begin
          cx <= CW'(nx_i);
          cy <= CW'(ny_i);
          if (last_step) begin
            state   <= ST_DONE;
            mv_x    <= CW'(nx_i);
            mv_y    <= CW'(ny_i);
            min_sad <= best_sad;
          end else begin
            state     <= ST_RUN;
            cnt       <= '0;
            step_dist <= step_dist >> 1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/logsearch_me.sv
`timescale 1ns/1ps
module logsearch_me
  import me_pkg::*;
#(
  parameter int PW       = 8,
  parameter int MB       = 16,
  parameter int SW       = 16,
  parameter int STEPS_LO = 3,
  parameter int STEPS_HI = 5,
  localparam int NPIX = MB * MB,
  localparam int PXW  = $clog2(NPIX),
  localparam int CNTW = $clog2(NPIX + 1),
  localparam int RMAX = (1 << STEPS_HI) - 1,
  localparam int WIN  = MB + 2 * RMAX,
  localparam int AW   = $clog2(WIN * WIN),
  localparam int CW   = $clog2(RMAX + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cur_we,
  input  logic [PXW-1:0]         cur_waddr,
  input  logic [PW-1:0]          cur_wdata,
  input  logic                   start,
  input  logic                   five_step,
  output logic [NLANE*AW-1:0]    ref_addr,
  input  logic [NLANE*PW-1:0]    ref_data,
  output logic                   busy,
  output logic                   done,
  output logic signed [CW-1:0]   mv_x,
  output logic signed [CW-1:0]   mv_y,
  output logic [SW-1:0]          min_sad
);
  me_state_t             state;
  logic [CNTW-1:0]       cnt;
  logic                  issue, rd_vld, clr;
  logic signed [CW-1:0]  cx, cy;
  logic [CW-1:0]         step_dist, lim;
  logic                  five_q, eval_evt, last_step;
  logic [2:0]            best_idx;
  logic [NLANE*SW-1:0]   sad_all;
  logic [PW-1:0]         cur_rd;
  logic [PXW-1:0]        pix;

  assign pix = cnt[PXW-1:0];

  me_curbuf #(.PW(PW), .DEPTH(NPIX), .AW(PXW)) u_buf (
    .clk(clk), .we(cur_we), .waddr(cur_waddr), .wdata(cur_wdata),
    .re(issue), .raddr(pix), .rdata(cur_rd)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    int   ox, oy, row, col;
    logic in_rng;

    always_comb begin
      ox     = int'(cx) + lane_dx(k) * int'(step_dist);
      oy     = int'(cy) + lane_dy(k) * int'(step_dist);
      row    = int'(pix) / MB;
      col    = int'(pix) % MB;
      in_rng = inside_box(ox, oy, int'(lim));
      ref_addr[k*AW +: AW] = AW'((RMAX + clamp_int(oy, RMAX) + row) * WIN
                                 + RMAX + clamp_int(ox, RMAX) + col);
    end

    me_pe #(.PW(PW), .SW(SW)) u_pe (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(rd_vld), .force_max(!in_rng),
      .cur_px(cur_rd), .ref_px(ref_data[k*PW +: PW]), .sad(sad_all[k*SW +: SW])
    );
  end

  me_ctrl #(
    .SW(SW), .NPIX(NPIX), .STEPS_LO(STEPS_LO), .STEPS_HI(STEPS_HI),
    .CW(CW), .CNTW(CNTW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .five_step(five_step),
    .sad_all(sad_all), .state(state), .cnt(cnt), .issue(issue), .rd_vld(rd_vld),
    .clr(clr), .cx(cx), .cy(cy), .step_dist(step_dist), .lim(lim), .five_q(five_q),
    .eval_evt(eval_evt), .last_step(last_step), .best_idx(best_idx),
    .busy(busy), .done(done), .mv_x(mv_x), .mv_y(mv_y), .min_sad(min_sad)
  );
endmodule

// File: rtl/me_chk.sv
`timescale 1ns/1ps
module me_chk
  import me_pkg::*;
#(
  parameter int SW       = 16,
  parameter int NPIX     = 256,
  parameter int STEPS_LO = 3,
  parameter int STEPS_HI = 5,
  parameter int CW       = 6,
  parameter int CNTW     = 9,
  parameter int AW       = 13,
  parameter int WIN      = 78
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input me_state_t            state,
  input logic [CNTW-1:0]      cnt,
  input logic                 issue,
  input logic                 rd_vld,
  input logic                 clr,
  input logic signed [CW-1:0] cx,
  input logic signed [CW-1:0] cy,
  input logic [CW-1:0]        step_dist,
  input logic [CW-1:0]        lim,
  input logic                 five_q,
  input logic                 eval_evt,
  input logic                 last_step,
  input logic [2:0]           best_idx,
  input logic [NLANE*SW-1:0]  sad_all,
  input logic [NLANE*AW-1:0]  ref_addr,
  input logic signed [CW-1:0] mv_x,
  input logic signed [CW-1:0] mv_y,
  input logic [SW-1:0]        min_sad
);
  logic [SW-1:0] s0, s1, s2, s3, s4;
  int a0, a1, a2, a3, a4, sd, lm;
  assign s0 = sad_all[0*SW +: SW];
  assign s1 = sad_all[1*SW +: SW];
  assign s2 = sad_all[2*SW +: SW];
  assign s3 = sad_all[3*SW +: SW];
  assign s4 = sad_all[4*SW +: SW];
  assign a0 = int'(ref_addr[0*AW +: AW]);
  assign a1 = int'(ref_addr[1*AW +: AW]);
  assign a2 = int'(ref_addr[2*AW +: AW]);
  assign a3 = int'(ref_addr[3*AW +: AW]);
  assign a4 = int'(ref_addr[4*AW +: AW]);
  assign sd = int'(step_dist);
  assign lm = int'(lim);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && !clr) |=> (s0 >= $past(s0)));
  p_lane_geom_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ((a0 - a1 == sd * WIN) && (a0 - a2 == sd) &&
               (a3 - a0 == sd) && (a4 - a0 == sd * WIN)));
  p_first_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sd == (five_q ? (1 << (STEPS_HI - 1)) : (1 << (STEPS_LO - 1)))));
  p_step_halve_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_evt && !last_step) |=> (step_dist == ($past(step_dist) >> 1)));
  p_mode_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |=> $stable(five_q));
  p_centre_tie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_evt && s0 <= s1 && s0 <= s2 && s0 <= s3 && s0 <= s4) |-> (best_idx == 3'd0));
  p_up_tie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_evt && s1 < s0 && s1 <= s2 && s1 <= s3 && s1 <= s4) |-> (best_idx == 3'd1));
  p_centre_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(cx) <= lm && int'(cx) >= -lm && int'(cy) <= lm && int'(cy) >= -lm));
  p_mv_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(mv_x) <= lm && int'(mv_x) >= -lm && int'(mv_y) <= lm && int'(mv_y) >= -lm));
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_EVAL) |=> ($stable(mv_x) && $stable(mv_y) && $stable(min_sad)));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == ST_RUN && cnt != CNTW'(NPIX)) |=>
      (state == ST_RUN && cnt == $past(cnt) + 1'b1));
endmodule

bind logsearch_me me_chk #(
  .SW(SW), .NPIX(NPIX), .STEPS_LO(STEPS_LO), .STEPS_HI(STEPS_HI),
  .CW(CW), .CNTW(CNTW), .AW(AW), .WIN(WIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .state(state), .cnt(cnt), .issue(issue), .rd_vld(rd_vld), .clr(clr),
  .cx(cx), .cy(cy), .step_dist(step_dist), .lim(lim), .five_q(five_q),
  .eval_evt(eval_evt), .last_step(last_step), .best_idx(best_idx),
  .sad_all(sad_all), .ref_addr(ref_addr), .mv_x(mv_x), .mv_y(mv_y),
  .min_sad(min_sad)
);

// File: tb/logsearch_me_tb.sv
`timescale 1ns/1ps
module logsearch_me_tb;
  localparam int WIN = 78;
  localparam int OFS = 31;
  localparam int AW  = 13;
  localparam int STEP_CYC = 258;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cur_we = 1'b0;
  logic [7:0]  cur_waddr = '0;
  logic [7:0]  cur_wdata = '0;
  logic        start = 1'b0;
  logic        five_step = 1'b0;
  logic [64:0] ref_addr;
  logic [39:0] ref_data = '0;
  logic        busy, done;
  logic signed [5:0] mv_x, mv_y;
  logic [15:0] min_sad;

  int n_checks = 0;
  int n_fail   = 0;
  int pat      = 0;
  int seed     = 1;
  int cur_px [256];
  int emx, emy, esad;

  always #4 clk = ~clk;

  logsearch_me u_dut (
    .clk(clk), .rst_n(rst_n), .cur_we(cur_we), .cur_waddr(cur_waddr),
    .cur_wdata(cur_wdata), .start(start), .five_step(five_step),
    .ref_addr(ref_addr), .ref_data(ref_data), .busy(busy), .done(done),
    .mv_x(mv_x), .mv_y(mv_y), .min_sad(min_sad)
  );

  // reference window contents as a function of window coordinates
  function automatic int ref_pix(input int x, input int y);
    int h;
    case (pat)
      0: begin
        h = (x * 7919 + y * 104729 + seed) * 40503;
        return (h >>> 9) & 255;
      end
      1: return 255;
      2: return (x >= 43 && y >= 43) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  // one-cycle read latency on every lane
  always @(posedge clk) begin
    for (int k = 0; k < 5; k++) begin
      ref_data[k*8 +: 8] <= 8'(ref_pix(int'(ref_addr[k*AW +: AW]) % WIN,
                                       int'(ref_addr[k*AW +: AW]) / WIN));
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int score(input int ox, input int oy);
    int s = 0;
    for (int p = 0; p < 256; p++) begin
      int d = cur_px[p] - ref_pix(OFS + ox + p % 16, OFS + oy + p / 16);
      s += (d < 0) ? -d : d;
    end
    return s;
  endfunction

  // behavioural log search
  task automatic model(input int n);
    int dxs[5] = '{0, 0, -1, 1, 0};
    int dys[5] = '{0, -1, 0, 0, 1};
    int s = 1 << (n - 1);
    int lm = (1 << n) - 1;
    int x = 0, y = 0;
    forever begin
      int bs = 0, bx = 0, by = 0;
      for (int k = 0; k < 5; k++) begin
        int tx = x + dxs[k] * s;
        int ty = y + dys[k] * s;
        int v = (tx > lm || tx < -lm || ty > lm || ty < -lm) ? 65535 : score(tx, ty);
        if (k == 0 || v < bs) begin bs = v; bx = tx; by = ty; end
      end
      x = bx; y = by;
      if (s == 1) begin esad = bs; break; end
      s = s / 2;
    end
    emx = x; emy = y;
  endtask

  task automatic load_cur();
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      cur_we = 1'b1; cur_waddr = 8'(p); cur_wdata = 8'(cur_px[p]);
    end
    @(negedge clk);
    cur_we = 1'b0;
  endtask

  task automatic cur_from_ref(input int sx, input int sy);
    for (int p = 0; p < 256; p++) cur_px[p] = ref_pix(OFS + sx + p % 16, OFS + sy + p / 16);
  endtask

  task automatic cur_const(input int v);
    for (int p = 0; p < 256; p++) cur_px[p] = v;
  endtask

  // inj >= 0: pulse start and flip five_step after edge inj of the run
  task automatic run_search(input bit fs, input int inj, input bit chk_addr, input string tag,
                            output int rx, output int ry, output int rs);
    int n = fs ? 5 : 3;
    int total = n * STEP_CYC;
    int errs = 0;
    int lm = (1 << n) - 1;
    int hx = 0, hy = 0, hs = 0;
    model(n);
    @(negedge clk);
    five_step = fs; start = 1'b1;
    for (int e = 0; e <= total + 1; e++) begin
      @(negedge clk);
      if (e == 0) start = 1'b0;
      if (e == 0 && chk_addr) begin
        int s = fs ? 16 : 4;
        int c = OFS * WIN + OFS;
        check(int'(ref_addr[0*AW +: AW]) == c, "R4 centre lane", int'(ref_addr[0*AW +: AW]), c);
        check(int'(ref_addr[1*AW +: AW]) == c - s * WIN, "R4 up lane", int'(ref_addr[1*AW +: AW]), c - s * WIN);
        check(int'(ref_addr[2*AW +: AW]) == c - s, "R4 left lane", int'(ref_addr[2*AW +: AW]), c - s);
        check(int'(ref_addr[3*AW +: AW]) == c + s, "R4 right lane", int'(ref_addr[3*AW +: AW]), c + s);
        check(int'(ref_addr[4*AW +: AW]) == c + s * WIN, "R4 down lane", int'(ref_addr[4*AW +: AW]), c + s * WIN);
      end
      if (inj >= 0 && e == inj) begin start = 1'b1; five_step = !fs; end
      if (inj >= 0 && e == inj + 1) start = 1'b0;
      if (busy !== (e < total) || done !== (e == total)) begin
        if (errs == 0)
          $display("FAIL R2 %s schedule at cycle %0d: busy=%0b done=%0b expected busy=%0b done=%0b",
                   tag, e, busy, done, e < total, e == total);
        errs++;
      end
      if (e == total) begin hx = $signed(mv_x); hy = $signed(mv_y); hs = int'(min_sad); end
    end
    five_step = fs;
    n_checks++;
    if (errs != 0) n_fail++;
    check(hx == emx, "R8 mv_x", hx, emx);
    check(hy == emy, "R8 mv_y", hy, emy);
    check(hs == esad, "R8 min_sad", hs, esad);
    check(hx <= lm && hx >= -lm && hy <= lm && hy >= -lm, "R7 mv inside range", hx, lm);
    check($signed(mv_x) == hx && $signed(mv_y) == hy && int'(min_sad) == hs,
          "R8 result held after done", int'(min_sad), hs);
    rx = hx; ry = hy; rs = hs;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int rx, ry, rs;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done in reset", int'(busy), 0);
    check(mv_x === 6'd0 && mv_y === 6'd0 && min_sad === 16'd0, "R1 result in reset", int'(min_sad), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && min_sad === 16'd0, "R1 after reset", int'(busy), 0);

    // R5/R10: three-step, exact match at (4,0) from the first step
    pat = 0; seed = 11; cur_from_ref(4, 0); load_cur();
    run_search(1'b0, -1, 1'b1, "3-step shift", rx, ry, rs);
    check(rx == 4 && ry == 0 && rs == 0, "R5 three-step finds (4,0)", rx * 100 + ry, 400);

    // R5: five-step, exact match at (16,0)
    seed = 23; cur_from_ref(16, 0); load_cur();
    run_search(1'b1, -1, 1'b1, "5-step shift", rx, ry, rs);
    check(rx == 16 && ry == 0 && rs == 0, "R5 five-step finds (16,0)", rx * 100 + ry, 1600);

    // R8: shifted image off the search grid, compared to model
    seed = 37; cur_from_ref(-3, 5); load_cur();
    run_search(1'b0, -1, 1'b0, "3-step odd shift", rx, ry, rs);

    // R8: unrelated random macroblock, five steps
    seed = 41;
    for (int p = 0; p < 256; p++) cur_px[p] = ((p * 131 + 17) * 73) & 255;
    load_cur();
    run_search(1'b1, -1, 1'b0, "5-step random", rx, ry, rs);

    // R3 worst case; R6 all tie, centre kept
    pat = 1; cur_const(0); load_cur();
    run_search(1'b0, -1, 1'b0, "worst case", rx, ry, rs);
    check(rs == 65280, "R3 worst-case score exact", rs, 65280);
    check(rx == 0 && ry == 0, "R6 full tie keeps centre", rx * 100 + ry, 0);

    // R6: up and left tie at zero, up wins
    pat = 2; cur_const(0); load_cur();
    run_search(1'b0, -1, 1'b0, "up-left tie", rx, ry, rs);
    check(rx == 0 && ry == -4 && rs == 0, "R6 up preferred over left", rx * 100 + ry, -4);

    // R9 start ignored while busy; R5 five_step change ignored
    pat = 0; seed = 57; cur_from_ref(2, -1); load_cur();
    run_search(1'b0, 100, 1'b0, "start while busy", rx, ry, rs);
    check(emx == rx && emy == ry, "R9 start while busy leaves result", rx * 100 + ry, emx * 100 + emy);

    // R8: result held while idle
    repeat (10) @(negedge clk);
    check(busy === 1'b0 && $signed(mv_x) == rx && $signed(mv_y) == ry && int'(min_sad) == rs,
          "R8 result held while idle", int'(min_sad), rs);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule